// File: doc/BRIEF.md
# Segment Address Translator Front End

This block sits in front of a page-table walker and decides, for each 32-bit virtual address, how it is to be translated. With translation switched off, the address passes straight through and the access is granted read, write and execute rights. With translation on, the top four address bits name one of sixteen segments. A per-segment mode bit decides whether that segment is mapped directly or has to go through a paged lookup.

A directly mapped segment keeps the low 28 address bits. Its top nibble is replaced by a 4-bit slot taken from two 32-bit base words. Segments 0 to 7 read their slot from the low base word and segments 8 to 15 from the high base word. Such an access gets full rights and never faults. For a segment in paged mode the block raises a request flag and leaves the lookup itself to the walker that follows.

The decision is made combinationally from the input strobe and registered once. One clock after each accepted request, the result appears together with a valid pulse. Between requests the registered result is held.

Top module: `segxlat`

## Requirements
- R1: Translation is on when bit 2 or bit 3 of `xlat_ctrl` is 1. When it is off, the result is `out_paddr` equal to the virtual address, `out_full_perm`=1 and `out_need_walk`=0, whatever `seg_mode` holds.
- R2: With translation on, the segment index is `in_vaddr[31:28]`. The segment is directly mapped when `seg_mode[index]` is 1.
- R3: With translation on and `seg_mode[index]`=0, the result is `out_need_walk`=1 and `out_full_perm`=0, and `out_paddr` equals the virtual address.
- R4: For a directly mapped segment s, `out_paddr[31:28]` is bits [4*(s mod 8)+3 : 4*(s mod 8)] of `base_lo` when s<8, and of `base_hi` when s>=8. `out_paddr[27:0]` equals `in_vaddr[27:0]`, with `out_full_perm`=1 and `out_need_walk`=0.
- R5: Whenever `out_valid` is 1, exactly one of `out_need_walk` and `out_full_perm` is 1.
- R6: `out_valid` is 1 in the cycle after a cycle with `in_valid`=1, and 0 in the cycle after a cycle with `in_valid`=0.
- R7: While `in_valid` is 0, `out_paddr`, `out_need_walk` and `out_full_perm` keep their previous values.
- R8: While `rst_n` is 0, all outputs are 0.
- R9: Bits of `xlat_ctrl` other than bits 2 and 3 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_vaddr | input | 32 | Virtual address |
| xlat_ctrl | input | 32 | Global control word; bits 2 and 3 enable translation |
| seg_mode | input | 16 | Per-segment direct-map select |
| base_lo | input | 32 | Base slots for segments 0 to 7 |
| base_hi | input | 32 | Base slots for segments 8 to 15 |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_paddr | output | 32 | Physical address |
| out_need_walk | output | 1 | Paged lookup required |
| out_full_perm | output | 1 | Read, write and execute granted without fault |

## Verification
The fault that is hardest to expose from the ports is picking the wrong slot. A design that reads the wrong base word, or the wrong nibble within it, gives correct results whenever the two slots involved happen to hold the same value. The stimulus therefore loads both base words with sixteen different nibbles. It sweeps every segment under a mode mask and under its complement, so each segment is seen both directly mapped and paged. Idle gaps test the hold rule. Control words with only the unrelated bits set, and mode masks changed while translation is off, test that those inputs are ignored.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ROUTE_IDENT = 2'd0,
    ROUTE_SEG   = 2'd1,
    ROUTE_WALK  = 2'd2
  } route_t;

  // Chooses how an access is handled from the enable state and the segment mode bit
  function automatic route_t pick_route(input logic on, input logic seg_direct);
    if (!on)            return ROUTE_IDENT;
    else if (seg_direct) return ROUTE_SEG;
    else                return ROUTE_WALK;
  endfunction

endpackage

// File: rtl/xlat_route_dec.sv
module xlat_route_dec
  import xlat_pkg::*;
#(
  parameter int CTRL_W     = 32,
  parameter int ENA_LO_BIT = 2,
  parameter int ENA_HI_BIT = 3,
  parameter int SEG_BITS   = 4,
  localparam int NUM_SEG   = 1 << SEG_BITS
) (
  input  logic [CTRL_W-1:0]   ctrl_word,
  input  logic [NUM_SEG-1:0]  mode_mask,
  input  logic [SEG_BITS-1:0] seg_idx,
  output logic                mmu_on,
  output logic                seg_direct,
  output route_t              route
);
  logic unused_ctrl;
  assign unused_ctrl = ^ctrl_word;

  assign mmu_on     = ctrl_word[ENA_LO_BIT] | ctrl_word[ENA_HI_BIT];
  assign seg_direct = mode_mask[seg_idx];
  assign route      = pick_route(mmu_on, seg_direct);
endmodule

// File: rtl/xlat_slot_pick.sv
module xlat_slot_pick #(
  parameter int SEG_BITS = 4,
  localparam int NUM_SEG = 1 << SEG_BITS,
  localparam int HALF    = NUM_SEG / 2,
  localparam int BASE_W  = HALF * SEG_BITS
) (
  input  logic [BASE_W-1:0]   base_lo,
  input  logic [BASE_W-1:0]   base_hi,
  input  logic [SEG_BITS-1:0] seg_idx,
  output logic [SEG_BITS-1:0] slot
);
  logic [SEG_BITS-1:0] slots [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_slot
    if (g < HALF) begin : g_lo
      assign slots[g] = base_lo[g*SEG_BITS +: SEG_BITS];
    end else begin : g_hi
      assign slots[g] = base_hi[(g-HALF)*SEG_BITS +: SEG_BITS];
    end
  end

  assign slot = slots[seg_idx];
endmodule

// File: rtl/xlat_out_stage.sv
module xlat_out_stage #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [VA_W-1:0] paddr_d,
  input  logic            walk_d,
  input  logic            full_d,
  output logic            valid_q,
  output logic [VA_W-1:0] paddr_q,
  output logic            walk_q,
  output logic            full_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      paddr_q <= '0;
      walk_q  <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) begin
        paddr_q <= paddr_d;
        walk_q  <= walk_d;
        full_q  <= full_d;
      end
    end
  end
endmodule

// File: rtl/segxlat.sv
module segxlat
  import xlat_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int SEG_BITS   = 4,
  parameter int CTRL_W     = 32,
  parameter int ENA_LO_BIT = 2,
  parameter int ENA_HI_BIT = 3,
  localparam int NUM_SEG   = 1 << SEG_BITS,
  localparam int BASE_W    = (NUM_SEG / 2) * SEG_BITS,
  localparam int OFS_W     = VA_W - SEG_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [VA_W-1:0]    in_vaddr,
  input  logic [CTRL_W-1:0]  xlat_ctrl,
  input  logic [NUM_SEG-1:0] seg_mode,
  input  logic [BASE_W-1:0]  base_lo,
  input  logic [BASE_W-1:0]  base_hi,
  output logic               out_valid,
  output logic [VA_W-1:0]    out_paddr,
  output logic               out_need_walk,
  output logic               out_full_perm
);
  logic [SEG_BITS-1:0] seg_idx;
  logic                mmu_on;
  logic                seg_hit;
  route_t              route;
  logic [SEG_BITS-1:0] new_top;
  logic [VA_W-1:0]     paddr_d;
  logic                walk_d;
  logic                full_d;

  assign seg_idx = in_vaddr[VA_W-1 -: SEG_BITS];

  xlat_route_dec #(
    .CTRL_W(CTRL_W), .ENA_LO_BIT(ENA_LO_BIT), .ENA_HI_BIT(ENA_HI_BIT),
    .SEG_BITS(SEG_BITS)
  ) u_route (
    .ctrl_word(xlat_ctrl), .mode_mask(seg_mode), .seg_idx(seg_idx),
    .mmu_on(mmu_on), .seg_direct(seg_hit), .route(route)
  );

  xlat_slot_pick #(.SEG_BITS(SEG_BITS)) u_slot (
    .base_lo(base_lo), .base_hi(base_hi), .seg_idx(seg_idx), .slot(new_top)
  );

  always_comb begin
    paddr_d = in_vaddr;
    walk_d  = 1'b0;
    full_d  = 1'b1;
    case (route)
      ROUTE_IDENT: ;
      ROUTE_SEG:   paddr_d = {new_top, in_vaddr[OFS_W-1:0]};
      default: begin
        walk_d = 1'b1;
        full_d = 1'b0;
      end
    endcase
  end

  xlat_out_stage #(.VA_W(VA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(in_valid),
    .paddr_d(paddr_d), .walk_d(walk_d), .full_d(full_d),
    .valid_q(out_valid), .paddr_q(out_paddr),
    .walk_q(out_need_walk), .full_q(out_full_perm)
  );
endmodule

// File: rtl/segxlat_chk.sv
module segxlat_chk #(
  parameter int VA_W     = 32,
  parameter int SEG_BITS = 4,
  localparam int OFS_W   = VA_W - SEG_BITS
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [VA_W-1:0] in_vaddr,
  input logic            mmu_on,
  input logic            seg_hit,
  input logic            out_valid,
  input logic [VA_W-1:0] out_paddr,
  input logic            out_need_walk,
  input logic            out_full_perm
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_need_walk, out_full_perm})); // R5
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_paddr[OFS_W-1:0] == $past(in_vaddr[OFS_W-1:0])); // R4
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mmu_on) |=> (out_paddr == $past(in_vaddr)) && out_full_perm); // R1
  AST_WALK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mmu_on && !seg_hit) |=> out_need_walk && (out_paddr == $past(in_vaddr))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_paddr) && $stable(out_need_walk) && $stable(out_full_perm)); // R7
endmodule

bind segxlat segxlat_chk #(.VA_W(VA_W), .SEG_BITS(SEG_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vaddr(in_vaddr),
  .mmu_on(mmu_on), .seg_hit(seg_hit), .out_valid(out_valid),
  .out_paddr(out_paddr), .out_need_walk(out_need_walk),
  .out_full_perm(out_full_perm)
);

// File: tb/segxlat_test.sv
module segxlat_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_vaddr = '0;
  logic [31:0] xlat_ctrl = '0;
  logic [15:0] seg_mode = '0;
  logic [31:0] base_lo = '0;
  logic [31:0] base_hi = '0;
  logic        out_valid;
  logic [31:0] out_paddr;
  logic        out_need_walk;
  logic        out_full_perm;

  int total = 0;
  int bad = 0;

  logic        e_valid = 1'b0;
  logic [31:0] e_paddr = '0;
  logic        e_walk = 1'b0;
  logic        e_full = 1'b0;

  always #10 clk = ~clk;

  segxlat uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vaddr(in_vaddr),
    .xlat_ctrl(xlat_ctrl), .seg_mode(seg_mode), .base_lo(base_lo),
    .base_hi(base_hi), .out_valid(out_valid), .out_paddr(out_paddr),
    .out_need_walk(out_need_walk), .out_full_perm(out_full_perm)
  );

  // Behavioural reference: plain integer arithmetic on the stated rules
  task automatic model(input logic [31:0] va);
    int seg;
    longint word;
    longint nib;
    bit on;
    on  = ((xlat_ctrl >> 2) & 3) != 0;
    seg = int'(va >> 28);
    if (!on) begin
      e_paddr = va; e_walk = 0; e_full = 1;
    end else if (((seg_mode >> seg) & 1) == 1) begin
      word = (seg < 8) ? longint'(base_lo) : longint'(base_hi);
      nib  = (word >> (4 * (seg % 8))) & 15;
      e_paddr = 32'(nib * 268435456 + (va % 268435456));
      e_walk = 0; e_full = 1;
    end else begin
      e_paddr = va; e_walk = 1; e_full = 0;
    end
  endtask

  task automatic check(input string tag);
    total++;
    if (out_valid !== e_valid || out_paddr !== e_paddr ||
        out_need_walk !== e_walk || out_full_perm !== e_full) begin
      bad++;
      $display("FAIL %s: got v=%0b pa=%h walk=%0b full=%0b exp v=%0b pa=%h walk=%0b full=%0b",
               tag, out_valid, out_paddr, out_need_walk, out_full_perm,
               e_valid, e_paddr, e_walk, e_full);
    end
  endtask

  // One clock: drive at falling edge, compare at next falling edge
  task automatic cyc(input logic v, input logic [31:0] va, input string tag);
    in_valid = v;
    in_vaddr = va;
    e_valid  = v;
    if (v) model(va);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    base_lo = 32'h7E3A_C051;
    base_hi = 32'h96DF_48B2;
    repeat (3) @(negedge clk);
    check("R8 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release");

    // Translation off: control zero, then only unrelated bits set
    xlat_ctrl = 32'h0;
    seg_mode  = 16'hFFFF;
    cyc(1, 32'h3123_4567, "R1 off pass");
    xlat_ctrl = 32'hFFFF_FFF3;
    cyc(1, 32'hA000_0ABC, "R9 unrelated ctrl bits");
    seg_mode = 16'h0000;
    cyc(1, 32'h5FFF_FFFF, "R9 R1 mode mask ignored when off");

    // Each enable bit on its own, plus both
    xlat_ctrl = 32'h0000_0004;
    seg_mode  = 16'h0002;
    cyc(1, 32'h1ABC_DEF0, "R2 R4 enable via bit 2");
    xlat_ctrl = 32'h0000_0008;
    cyc(1, 32'h1ABC_DEF0, "R2 R4 enable via bit 3");
    xlat_ctrl = 32'hF0F0_F0FC;
    cyc(1, 32'h2000_0001, "R3 paged with noisy ctrl R9");

    // Sweep all segments with a mixed mask and then its complement
    for (int pass = 0; pass < 2; pass++) begin
      seg_mode = (pass == 0) ? 16'hA5C3 : 16'h5A3C;
      for (int s = 0; s < 16; s++) begin
        cyc(1, {4'(s), 28'h0F0_5A5A + 28'(s * 4099)}, "R4 R3 R5 segment sweep");
      end
    end

    // All segments direct-mapped, with idle gaps between requests
    seg_mode = 16'hFFFF;
    for (int s = 0; s < 16; s++) begin
      cyc(1, {4'(15 - s), 28'hFFF_FFFF - 28'(s * 77)}, "R4 full direct map");
      cyc(0, 32'hDEAD_BEEF, "R7 R6 hold on idle");
    end

    // Inputs change during idle: the held result must not move
    cyc(1, 32'h8765_4321, "R4 high word slot 0");
    xlat_ctrl = 32'h0;
    base_hi = 32'h0;
    cyc(0, 32'h0000_0000, "R7 idle with new config");
    cyc(0, 32'h1111_1111, "R7 R6 idle second");

    // Reset in mid-stream
    in_valid = 1'b1;
    rst_n = 1'b0;
    e_valid = 0; e_paddr = '0; e_walk = 0; e_full = 0;
    @(negedge clk);
    check("R8 reset mid-stream");
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after second release");
    cyc(1, 32'h4444_0000, "R1 off after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule